// File: doc/BRIEF.md
# PDM Microphone Output Interface

This block is the digital end of a microphone that delivers its audio as a one-bit pulse-density stream. A host supplies the bit clock and may put two microphones on one data wire. Each microphone drives the wire during one half of every bit-clock period and releases it for the other half, and a channel-select input picks which half. The bit stream from the modulator enters on a plain input port. The wire is modelled as a data bit plus an output enable, where enable low means high impedance.

A free-running reference clock times every part of the block. The bit clock is synchronised into that domain, and both of its edges are detected there. Bit-clock rising edges are counted over a fixed window of reference cycles. A window with enough edges wakes the block, and a window with very few edges sends it to sleep. Counts between the two thresholds leave the state as it is. After wake-up, a settle phase covers a parameterised number of drive edges. In the default build the settle phase sends a neutral 1/0 pattern, and in the other build the wire stays released. While asleep, the wire is always released.

Top module: `pdm_mic_port`

## Requirements
- R1: With `chan_sel` = 0 and the block active, each falling bit-clock edge drives the wire (`dout_oe` = 1) with `dout` equal to `mod_bit` as sampled at that edge, held until the next rising edge, which releases the wire (`dout_oe` = 0).
- R2: With `chan_sel` = 1 the edge roles swap: a rising edge drives and a falling edge releases. A change of `chan_sel` made while the wire is released takes effect from the next bit-clock edge.
- R3: After a drive or release edge on `bclk`, the outputs reach their new value no later than 4 reference cycles later.
- R4: The block leaves sleep at the end of a measurement window that holds at least ceil(300 kHz × window / reference rate) rising edges, which is 15 with the defaults (250 MHz reference, 12500-cycle window). With a steady 2.5 MHz clock, the first driven bit comes no more than two windows after the clock starts.
- R5: A window holding no more than floor(70 kHz × window / reference rate) rising edges (3 with the defaults) puts the block to sleep at the end of that window, from any state.
- R6: A window count between the two thresholds leaves the state unchanged. A 150 kHz clock therefore keeps an active block active and a sleeping block asleep.
- R7: After reset and in sleep the wire stays released (`dout_oe` = 0), whether or not `bclk` toggles.
- R8: With the default settle mode, the first 16 drive edges after wake-up drive the pattern 1,0,1,0,… whatever `mod_bit` is. The 17th drive edge drives `mod_bit`.
- R9: With the quiet settle mode (`SETTLE_DRIVE` = 0), the wire stays released for those 16 drive edges, and the 17th drive edge drives `mod_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked by it |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Incoming bit clock from the host, asynchronous to ref_clk |
| chan_sel | input | 1 | 0: drive after falling edge; 1: drive after rising edge |
| mod_bit | input | 1 | One-bit modulator output to be sent |
| dout | output | 1 | Data value placed on the shared wire |
| dout_oe | output | 1 | Wire drive enable; 0 means released (high impedance) |

## Verification
The assertions take for granted three things about the inputs. Each `bclk` level lasts at least two reference cycles, so the synchroniser sees every edge. `chan_sel` is stable around bit-clock edges. `mod_bit` is steady at the moment a drive edge is detected. The stimulus places every bit-clock transition on a reference falling edge and keeps bit-clock half-periods at 200 ns or longer. It changes `chan_sel` and `mod_bit` only while the wire is released. Rate changes are followed by more than two full windows before a state is checked, so a window that mixes two rates never decides an outcome.

// File: rtl/pdm_mic_pkg.sv
// Package for the PDM output interface.
// Holds the power-state encoding that the controller and the output stage share.
package pdm_mic_pkg;

    typedef enum logic [1:0] {
        PWR_SLEEP  = 2'd0,
        PWR_SETTLE = 2'd1,
        PWR_ACTIVE = 2'd2
    } pwr_state_t;

endpackage

// File: rtl/pdm_edge_sync.sv
// Synchroniser and edge detector for the incoming bit clock.
// The asynchronous input passes through SYNC_STAGES flops, and one more flop
// gives the edge compare. Assumes each input level lasts two or more ref cycles.
module pdm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_p,
    output logic fall_p
);

    logic [SYNC_STAGES:0] pipe_q;

    // Shift the asynchronous level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], async_in};
        end
    end

    // Compare the last synchronised level with the one before it.
    always_comb begin
        rise_p = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
        fall_p = ~pipe_q[SYNC_STAGES-1] & pipe_q[SYNC_STAGES];
    end

endmodule

// File: rtl/pdm_rate_monitor.sv
// Bit-clock rate monitor.
// Counts edge pulses over a window of WIN_CYC reference cycles. At the end of
// each window it pulses win_done for one cycle, together with two verdicts:
// rate_fast (count >= WAKE_EDGES) and rate_slow (count <= SLEEP_EDGES).
// The counter stops at WAKE_EDGES, because no verdict needs a higher value.
// Assumes SLEEP_EDGES < WAKE_EDGES and WIN_CYC >= 2.
module pdm_rate_monitor #(
    parameter int WIN_CYC     = 12500,
    parameter int WAKE_EDGES  = 15,
    parameter int SLEEP_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_p,
    output logic win_done,
    output logic rate_fast,
    output logic rate_slow
);

    localparam int WW = $clog2(WIN_CYC);
    localparam int CW = $clog2(WAKE_EDGES + 1);

    logic [WW-1:0] win_cnt_q;
    logic [CW-1:0] edge_cnt_q;
    logic [CW-1:0] cnt_now;
    logic          win_end;

    // Work out the edge count including this cycle's pulse, stopping at the cap.
    always_comb begin
        win_end = (win_cnt_q == WW'(WIN_CYC - 1));
        cnt_now = edge_cnt_q;
        if (edge_p && (edge_cnt_q != CW'(WAKE_EDGES))) begin
            cnt_now = edge_cnt_q + CW'(1);
        end
    end

    // Step the window, and pass the verdicts on when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt_q  <= '0;
            edge_cnt_q <= '0;
            win_done   <= 1'b0;
            rate_fast  <= 1'b0;
            rate_slow  <= 1'b0;
        end else begin
            win_done <= win_end;
            if (win_end) begin
                win_cnt_q  <= '0;
                edge_cnt_q <= '0;
                rate_fast  <= (cnt_now >= CW'(WAKE_EDGES));
                rate_slow  <= (cnt_now <= CW'(SLEEP_EDGES));
            end else begin
                win_cnt_q  <= win_cnt_q + WW'(1);
                edge_cnt_q <= cnt_now;
            end
        end
    end

    AST_WIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done); // R4

endmodule

// File: rtl/pdm_power_ctrl.sv
// Sleep / settle / active controller.
// Acts on the window verdicts only. A slow window sends any state to sleep,
// and a fast window wakes a sleeping block into the settle phase. The settle
// phase lasts SETTLE_EDGES drive edges, then the block becomes active.
// settle_odd is the low bit of the settle edge index.
// Assumes SETTLE_EDGES >= 1.
module pdm_power_ctrl
    import pdm_mic_pkg::*;
#(
    parameter int SETTLE_EDGES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_done,
    input  logic       rate_fast,
    input  logic       rate_slow,
    input  logic       drv_evt,
    output pwr_state_t state,
    output logic       settle_odd
);

    localparam int SW = (SETTLE_EDGES > 1) ? $clog2(SETTLE_EDGES) : 1;

    logic [SW-1:0] scnt_q;

    // Move between states on window verdicts and count the settle edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PWR_SLEEP;
            scnt_q <= '0;
        end else begin
            case (state)
                PWR_SLEEP: begin
                    if (win_done && rate_fast) begin
                        state  <= PWR_SETTLE;
                        scnt_q <= '0;
                    end
                end
                PWR_SETTLE: begin
                    if (win_done && rate_slow) begin
                        state <= PWR_SLEEP;
                    end else if (drv_evt) begin
                        if (scnt_q == SW'(SETTLE_EDGES - 1)) begin
                            state <= PWR_ACTIVE;
                        end else begin
                            scnt_q <= scnt_q + SW'(1);
                        end
                    end
                end
                PWR_ACTIVE: begin
                    if (win_done && rate_slow) begin
                        state <= PWR_SLEEP;
                    end
                end
                default: state <= PWR_SLEEP;
            endcase
        end
    end

    // Pass the settle index parity on to the output stage.
    always_comb settle_odd = scnt_q[0];

    AST_WAKE_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PWR_SLEEP && state != PWR_SLEEP) |-> $past(win_done && rate_fast)); // R4

    AST_SLEEP_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != PWR_SLEEP && state == PWR_SLEEP) |-> $past(win_done && rate_slow)); // R5

    AST_WAKE_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PWR_SLEEP) |-> (state != PWR_ACTIVE)); // R8

endmodule

// File: rtl/pdm_out_stage.sv
// Drive/release stage for the shared data wire.
// A drive event turns the enable on and loads a bit. A release event turns the
// enable off. In sleep the enable is held off. SETTLE_DRIVE chooses what the
// settle phase sends: an alternating 1/0 pattern, or a released wire.
module pdm_out_stage
    import pdm_mic_pkg::*;
#(
    parameter bit SETTLE_DRIVE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_evt,
    input  logic       rel_evt,
    input  pwr_state_t state,
    input  logic       settle_odd,
    input  logic       mod_bit,
    output logic       dout,
    output logic       dout_oe
);

    logic settle_oe;
    logic settle_bit;

    generate
        if (SETTLE_DRIVE) begin : g_settle_pattern
            // Settle phase sends 1 on even settle edges and 0 on odd ones.
            always_comb begin
                settle_oe  = 1'b1;
                settle_bit = ~settle_odd;
            end
        end else begin : g_settle_quiet
            // Settle phase leaves the wire released.
            always_comb begin
                settle_oe  = 1'b0;
                settle_bit = 1'b0;
            end
        end
    endgenerate

    // Update enable and data on drive and release events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_oe <= 1'b0;
            dout    <= 1'b0;
        end else if (state == PWR_SLEEP) begin
            dout_oe <= 1'b0;
        end else if (drv_evt) begin
            if (state == PWR_ACTIVE) begin
                dout_oe <= 1'b1;
                dout    <= mod_bit;
            end else begin
                dout_oe <= settle_oe;
                dout    <= settle_bit;
            end
        end else if (rel_evt) begin
            dout_oe <= 1'b0;
        end
    end

    AST_SLEEP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PWR_SLEEP && $past(state) == PWR_SLEEP) |-> !dout_oe); // R7

    AST_DATA_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_evt && state == PWR_ACTIVE) |=> (dout_oe && dout == $past(mod_bit))); // R1

    AST_RELEASE_ON_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_evt |=> !dout_oe); // R2

endmodule

// File: rtl/pdm_mic_port.sv
// PDM microphone output interface, top level.
// Synchronises the bit clock, measures its rate to decide sleep or wake,
// and drives the shared data wire during the half period that chan_sel picks.
// Wake and sleep thresholds come from frequencies in kHz, converted to edge
// counts per window. Assumes bclk runs well below REF_KHZ / 4.
module pdm_mic_port
    import pdm_mic_pkg::*;
#(
    parameter int REF_KHZ      = 250000,
    parameter int WAKE_KHZ     = 300,
    parameter int SLEEP_KHZ    = 70,
    parameter int WIN_CYC      = 12500,
    parameter int SETTLE_EDGES = 16,
    parameter bit SETTLE_DRIVE = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic chan_sel,
    input  logic mod_bit,
    output logic dout,
    output logic dout_oe
);

    localparam int WAKE_EDGES  = (WAKE_KHZ * WIN_CYC + REF_KHZ - 1) / REF_KHZ;
    localparam int SLEEP_EDGES = (SLEEP_KHZ * WIN_CYC) / REF_KHZ;

    logic       bclk_rise;
    logic       bclk_fall;
    logic       drv_evt;
    logic       rel_evt;
    logic       win_done;
    logic       rate_fast;
    logic       rate_slow;
    logic       settle_odd;
    pwr_state_t pwr_state;

    pdm_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .async_in(bclk),
        .rise_p  (bclk_rise),
        .fall_p  (bclk_fall)
    );

    pdm_rate_monitor #(
        .WIN_CYC    (WIN_CYC),
        .WAKE_EDGES (WAKE_EDGES),
        .SLEEP_EDGES(SLEEP_EDGES)
    ) u_rate (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .edge_p   (bclk_rise),
        .win_done (win_done),
        .rate_fast(rate_fast),
        .rate_slow(rate_slow)
    );

    // Pick which bit-clock edge drives and which releases.
    always_comb begin
        drv_evt = chan_sel ? bclk_rise : bclk_fall;
        rel_evt = chan_sel ? bclk_fall : bclk_rise;
    end

    pdm_power_ctrl #(
        .SETTLE_EDGES(SETTLE_EDGES)
    ) u_power (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .win_done  (win_done),
        .rate_fast (rate_fast),
        .rate_slow (rate_slow),
        .drv_evt   (drv_evt),
        .state     (pwr_state),
        .settle_odd(settle_odd)
    );

    pdm_out_stage #(
        .SETTLE_DRIVE(SETTLE_DRIVE)
    ) u_out (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .drv_evt   (drv_evt),
        .rel_evt   (rel_evt),
        .state     (pwr_state),
        .settle_odd(settle_odd),
        .mod_bit   (mod_bit),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    AST_DRIVE_ONLY_ON_SELECTED_EDGE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(drv_evt)); // R1

endmodule

// File: tb/pdm_mic_port_bench.sv
// Directed bench for pdm_mic_port: one task per scenario, each checking itself.
module pdm_mic_port_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic chan_sel = 1'b0;
    logic mod_bit = 1'b0;
    logic dout, dout_oe;
    logic dout_q, dout_oe_q;
    int   bclk_half = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    // Bit-clock source; every transition lands on a multiple of 4 ns.
    always begin
        if (bclk_half == 0) begin
            bclk = 1'b0;
            #4;
        end else begin
            #(bclk_half) bclk = ~bclk;
        end
    end

    pdm_mic_port u_pdm_mic_port (
        .ref_clk(clk), .rst_n(rst_n), .bclk(bclk), .chan_sel(chan_sel),
        .mod_bit(mod_bit), .dout(dout), .dout_oe(dout_oe)
    );

    pdm_mic_port #(.SETTLE_DRIVE(1'b0)) u_pdm_mic_port_quiet (
        .ref_clk(clk), .rst_n(rst_n), .bclk(bclk), .chan_sel(chan_sel),
        .mod_bit(mod_bit), .dout(dout_q), .dout_oe(dout_oe_q)
    );

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        #40;
        rst_n = 1'b1;
        #8;
        chk("R7 reset released", {1'b0, dout_oe}, 2'b00);
        chk("R7 reset released quiet", {1'b0, dout_oe_q}, 2'b00);
    endtask

    task automatic t_idle_sleep;
        bclk_half = 0;
        #20000;
        chk("R7 idle sleep", {1'b0, dout_oe}, 2'b00);
    endtask

    task automatic t_wake;
        int waited = 0;
        bclk_half = 200;
        while (!dout_oe && waited < 150000) begin
            #4;
            waited += 4;
        end
        chk("R4 wake time", {1'b0, waited <= 100400}, 2'b01);
        chk("R8 settle edge 0", {dout_oe, dout}, 2'b11);
        chk("R9 quiet settle 0", {1'b0, dout_oe_q}, 2'b00);
        for (int k = 1; k < 16; k++) begin
            @(posedge bclk); #16;
            chk("R1 settle release", {1'b0, dout_oe}, 2'b00);
            mod_bit = ~mod_bit;
            @(negedge bclk); #16;
            chk("R8 settle pattern", {dout_oe, dout}, {1'b1, (k % 2 == 0)});
            chk("R9 quiet settle", {1'b0, dout_oe_q}, 2'b00);
        end
        @(posedge bclk); #16;
        mod_bit = 1'b0;
        @(negedge bclk); #16;
        chk("R8 first data after settle", {dout_oe, dout}, 2'b10);
        chk("R9 first data after quiet settle", {dout_oe_q, dout_q}, 2'b10);
    endtask

    task automatic t_data_sel0;
        logic [7:0] pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) begin
            @(posedge bclk); #16;
            chk("R1 release after rise", {1'b0, dout_oe}, 2'b00);
            mod_bit = pat[i];
            @(negedge bclk); #16;
            chk("R3 drive within 4 cycles", {dout_oe, dout}, {1'b1, pat[i]});
            mod_bit = ~pat[i];
            #80;
            chk("R1 data held in half", {dout_oe, dout}, {1'b1, pat[i]});
        end
    endtask

    task automatic t_data_sel1;
        logic [5:0] pat = 6'b01_1010;
        @(posedge bclk); #16;
        chan_sel = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge bclk); #16;
            chk("R2 release after fall", {1'b0, dout_oe}, 2'b00);
            mod_bit = pat[i];
            @(posedge bclk); #16;
            chk("R2 drive after rise", {dout_oe, dout}, {1'b1, pat[i]});
        end
        @(negedge bclk); #16;
        chan_sel = 1'b0;
        mod_bit = 1'b1;
    endtask

    task automatic t_mid_keeps_active;
        bclk_half = 3332;
        #100000;
        @(posedge bclk); #16;
        mod_bit = 1'b1;
        @(negedge bclk); #16;
        chk("R6 mid rate stays active", {dout_oe, dout}, 2'b11);
    endtask

    task automatic t_slow_sleeps;
        bclk_half = 12500;
        #120000;
        @(negedge bclk); #16;
        chk("R5 slow clock sleeps", {1'b0, dout_oe}, 2'b00);
        chk("R5 slow clock sleeps quiet", {1'b0, dout_oe_q}, 2'b00);
        @(posedge bclk); #16;
        chk("R7 sleep with toggling clock", {1'b0, dout_oe}, 2'b00);
    endtask

    task automatic t_mid_keeps_sleep;
        bclk_half = 3332;
        #120000;
        @(negedge bclk); #16;
        chk("R6 mid rate stays asleep", {1'b0, dout_oe}, 2'b00);
        @(negedge bclk); #16;
        chk("R6 mid rate stays asleep again", {1'b0, dout_oe}, 2'b00);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_idle_sleep();
        t_wake();
        t_data_sel0();
        t_data_sel1();
        t_mid_keeps_active();
        t_slow_sleeps();
        t_mid_keeps_sleep();
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        #(190000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule